// File: doc/BRIEF.md
# Multi-Mode Sensor Sample FIFO

This block buffers up to 32 three-axis sample sets (X, Y, Z) between a sensor front end and a host read port. A new set is offered on a write strobe at the output data rate. The host pops the oldest set through a read strobe, and the head set is always visible on the read data outputs. A single control byte selects one of four fill policies:

- **Bypass:** nothing is stored.
- **Stop-when-full:** incoming sets are dropped once the buffer is full.
- **Circular overwrite:** the oldest set is replaced when the buffer is full.
- **Circular-then-freeze:** behaves as circular overwrite until one of two selectable event inputs asserts, and from then on behaves as stop-when-full.

A status byte reports four fields: a watermark flag, a sticky overrun flag, an empty flag and the number of unread sets.

The controller is a state machine with five states.

- **Reset and bypass:**
  - `ST_BYPASS` is the state after reset.
  - A control write with mode 00 also goes to `ST_BYPASS`.
- **Other mode writes:** any control write moves the machine to the state its mode field names.
  - Mode 01 selects `ST_HOLD`.
  - Mode 10 selects `ST_RING`.
  - Mode 11 selects `ST_RING_ARMED`.
- **Trigger transition:** `ST_RING_ARMED` moves to `ST_FROZEN` when the selected event input is high at a clock edge.
- **Staying put:** with no control write, every other state holds.

The storage datapath keeps the pointers and the unread count. A small formatter builds the status byte.

Top module: `sensor_set_fifo`

## Requirements
- R1: Control byte layout:
  - Bits 7:6 select the policy: 00 bypass, 01 stop-when-full, 10 circular, 11 circular-then-freeze.
  - Bit 5 selects the freeze trigger: 0 is `evt_a`, 1 is `evt_b`.
  - Bits 4:0 hold the watermark level.
  - Every control write empties the buffer, clears the unread count and disarms the freeze.
  - A sample offered in the same cycle as a control write is not stored.
- R2: In bypass no sample is stored. The status keeps empty=1 and count=0, and reads have no effect.
- R3: In stop-when-full mode, sets are stored until 32 are held. Further sets are discarded while the buffer is full, and the stored contents do not change.
- R4: In circular mode, a set written while 32 are held replaces the oldest. The head then shows the next-oldest set, and the count stays at 32.
- R5: Circular-then-freeze mode behaves as circular until the selected event input is high at a clock edge.
  - From the following cycle on, it behaves as stop-when-full until the next control write.
  - The unselected event input has no effect.
  - A sample in the trigger cycle itself still follows circular behaviour.
- R6: Status byte layout:
  - Bit 7 is the watermark flag.
  - Bit 6 is the overrun flag.
  - Bit 5 is the empty flag, high when no unread set is held.
  - Bits 4:0 are the unread count, which reports 31 while 32 sets are held.
- R7: The overrun flag is high exactly while 32 unread sets are held. It clears on the first read after that.
- R8: The watermark flag is high exactly when the unread count (0 to 32) is greater than the programmed watermark level.
- R9: Read port behaviour:
  - While at least one set is held, `rd_x`/`rd_y`/`rd_z` show the oldest set, and a read strobe removes it at the clock edge.
  - A read of an empty buffer is ignored.
  - A read and a write in the same cycle both take effect, even when the buffer is full.
- R10: After reset the policy is bypass, the watermark level is 0, and the status byte is 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte (mode, trigger select, watermark level) |
| smp_valid | input | 1 | New sample set strobe |
| smp_x | input | 16 | X axis sample |
| smp_y | input | 16 | Y axis sample |
| smp_z | input | 16 | Z axis sample |
| evt_a | input | 1 | Freeze trigger event, first source |
| evt_b | input | 1 | Freeze trigger event, second source |
| rd_en | input | 1 | Pop strobe for the oldest set |
| rd_x | output | 16 | X axis of the oldest set |
| rd_y | output | 16 | Y axis of the oldest set |
| rd_z | output | 16 | Z axis of the oldest set |
| status | output | 8 | Watermark, overrun, empty and unread count |

## Verification
A wrong pointer or count shows up within one cycle as a status byte that disagrees with the number of sets the bench has queued, or as head data that is not the oldest queued set. A wrong freeze state does not show until the buffer is full and another sample arrives. At that point the head either advances when it should stay, or stays when it should advance. The bench therefore fills the buffer past 32 in every policy and compares status and head after every clock.

// File: rtl/sensor_set_fifo_pkg.sv
package sensor_set_fifo_pkg;
    typedef enum logic [2:0] {
        ST_BYPASS,
        ST_HOLD,
        ST_RING,
        ST_RING_ARMED,
        ST_FROZEN
    } fill_state_t;

    localparam logic [1:0] MODE_BYPASS = 2'b00;
    localparam logic [1:0] MODE_HOLD   = 2'b01;
    localparam logic [1:0] MODE_RING   = 2'b10;
    localparam logic [1:0] MODE_ARMED  = 2'b11;
endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import sensor_set_fifo_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_trig,
    input  logic [LVL_W-1:0] cfg_level,
    input  logic             evt_a,
    input  logic             evt_b,
    input  logic             smp_valid,
    input  logic             full,
    input  logic             pop,
    output logic             push,
    output logic [LVL_W-1:0] level
);
    fill_state_t state, state_nx;
    logic        trig_sel;
    logic        trig_hit;
    logic        store_on;
    logic        circular;

    assign trig_hit = trig_sel ? evt_b : evt_a;

    always_comb begin
        state_nx = state;
        if (cfg_we) begin
            unique case (cfg_mode)
                MODE_BYPASS: state_nx = ST_BYPASS;
                MODE_HOLD:   state_nx = ST_HOLD;
                MODE_RING:   state_nx = ST_RING;
                MODE_ARMED:  state_nx = ST_RING_ARMED;
            endcase
        end else if (state == ST_RING_ARMED && trig_hit) begin
            state_nx = ST_FROZEN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_BYPASS;
            trig_sel <= 1'b0;
            level    <= '0;
        end else begin
            state <= state_nx;
            if (cfg_we) begin
                trig_sel <= cfg_trig;
                level    <= cfg_level;
            end
        end
    end

    always_comb begin
        store_on = 1'b1;
        circular = 1'b0;
        unique case (state)
            ST_BYPASS:     store_on = 1'b0;
            ST_HOLD:       circular = 1'b0;
            ST_RING:       circular = 1'b1;
            ST_RING_ARMED: circular = 1'b1;
            ST_FROZEN:     circular = 1'b0;
            default:       store_on = 1'b0;
        endcase
        push = smp_valid && !cfg_we && store_on && (!full || pop || circular);
    end

    assert_bypass_no_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BYPASS) |-> !push);

    assert_freeze_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FROZEN && !cfg_we) |=> (state == ST_FROZEN));

    assert_hold_drops_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HOLD || state == ST_FROZEN) && full && !pop) |-> !push);
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int DATA_W = 48,
    parameter int DEPTH  = 32,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [CNT_W-1:0]  count,
    output logic              full
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              overwrite;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full      = (count == CNT_W'(DEPTH));
    assign overwrite = push && !pop && full;
    assign dout      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push && !clr) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)             wr_ptr <= bump(wr_ptr);
            if (pop || overwrite) rd_ptr <= bump(rd_ptr);
            if (push && !pop && !full) count <= count + CNT_W'(1);
            else if (pop && !push)     count <= count - CNT_W'(1);
        end
    end

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (int'(count) - int'($past(count)) <= 1 && int'($past(count)) - int'(count) <= 1));
endmodule

// File: rtl/sfifo_status.sv
module sfifo_status #(
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int LVL_W = 5
) (
    input  logic [CNT_W-1:0] count,
    input  logic [LVL_W-1:0] level,
    output logic [7:0]       status
);
    logic [LVL_W-1:0] cnt_field;

    assign cnt_field = (count >= CNT_W'(2**LVL_W - 1)) ? {LVL_W{1'b1}} : count[LVL_W-1:0];

    always_comb begin
        status[7]   = (int'(count) > int'(level));
        status[6]   = (count == CNT_W'(DEPTH));
        status[5]   = (count == '0);
        status[4:0] = cnt_field;
    end
endmodule

// File: rtl/sensor_set_fifo.sv
module sensor_set_fifo #(
    parameter int AXIS_W = 16,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic              smp_valid,
    input  logic [AXIS_W-1:0] smp_x,
    input  logic [AXIS_W-1:0] smp_y,
    input  logic [AXIS_W-1:0] smp_z,
    input  logic              evt_a,
    input  logic              evt_b,
    input  logic              rd_en,
    output logic [AXIS_W-1:0] rd_x,
    output logic [AXIS_W-1:0] rd_y,
    output logic [AXIS_W-1:0] rd_z,
    output logic [7:0]        status
);
    localparam int DATA_W = 3 * AXIS_W;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int LVL_W  = 5;

    logic [CNT_W-1:0]  count;
    logic [LVL_W-1:0]  level;
    logic [DATA_W-1:0] head;
    logic              full, push, pop;

    assign pop = rd_en && !cfg_we && (count != '0);

    sfifo_ctrl #(.LVL_W(LVL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_mode(cfg_wdata[7:6]), .cfg_trig(cfg_wdata[5]), .cfg_level(cfg_wdata[4:0]),
        .evt_a(evt_a), .evt_b(evt_b), .smp_valid(smp_valid),
        .full(full), .pop(pop), .push(push), .level(level)
    );

    sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(cfg_we), .push(push), .pop(pop),
        .din({smp_x, smp_y, smp_z}), .dout(head), .count(count), .full(full)
    );

    sfifo_status #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_status (
        .count(count), .level(level), .status(status)
    );

    assign {rd_x, rd_y, rd_z} = head;

    assert_overrun_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] |-> (status[4:0] == 5'd31 && !status[5]));

    assert_cfg_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (status[5] && status[4:0] == 5'd0));

    assert_empty_read_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !smp_valid && !cfg_we) |=> status[5]);
endmodule

// File: tb/sensor_set_fifo_tb.sv
module sensor_set_fifo_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic        evt_a = 1'b0, evt_b = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_x, rd_y, rd_z;
    logic [7:0]  status;

    int checks = 0;
    int errors = 0;
    logic [47:0] q[$];
    int  m_mode = 0;
    bit  m_frozen = 0;
    bit  m_sel = 0;
    int  m_lvl = 0;
    int  seq = 1;
    string tag = "R10";

    always #(CLK_PERIOD/2) clk = ~clk;

    sensor_set_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .evt_a(evt_a), .evt_b(evt_b), .rd_en(rd_en),
        .rd_x(rd_x), .rd_y(rd_y), .rd_z(rd_z), .status(status)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        int n = q.size();
        chk("R8", 64'(status[7]), 64'(n > m_lvl));
        chk("R7", 64'(status[6]), 64'(n == 32));
        chk("R6", 64'(status[5:0]), 64'({n == 0, (n >= 31) ? 5'd31 : 5'(n)}));
        if (n > 0) chk(tag, 64'({rd_x, rd_y, rd_z}), 64'(q[0]));
    endtask

    // one clock: inputs given, model updated, outputs compared after the edge
    task automatic step(input bit we, input logic [7:0] cfg, input bit wr,
                        input bit rd, input bit ea, input bit eb);
        logic [47:0] s;
        bit pop, circ;
        s = {16'(seq), 16'(seq * 3 + 7), 16'(seq ^ 16'h5a5a)};
        seq++;
        cfg_we = we; cfg_wdata = cfg; smp_valid = wr; rd_en = rd;
        evt_a = ea; evt_b = eb;
        {smp_x, smp_y, smp_z} = s;
        if (we) begin
            q.delete();
            m_mode = int'(cfg[7:6]); m_sel = cfg[5]; m_lvl = int'(cfg[4:0]); m_frozen = 0;
        end else begin
            pop  = rd && q.size() > 0;
            circ = (m_mode == 2) || (m_mode == 3 && !m_frozen);
            if (pop) void'(q.pop_front());
            if (wr && m_mode != 0) begin
                if (q.size() < 32) q.push_back(s);
                else if (circ) begin void'(q.pop_front()); q.push_back(s); end
            end
            if (m_mode == 3 && !m_frozen && (m_sel ? eb : ea)) m_frozen = 1;
        end
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R10";
        chk("R10", 64'(status), 64'h20);
        compare();

        tag = "R2";
        for (int i = 0; i < 6; i++) step(0, 8'h00, 1, i[0], 0, 0);
        chk("R2", 64'(status), 64'h20);

        tag = "R3";
        step(1, 8'h44, 1, 0, 0, 0);            // stop-when-full, level 4 (R1)
        chk("R1", 64'(status), 64'h20);
        for (int i = 0; i < 40; i++) step(0, 8'h00, 1, 0, 0, 0);
        chk("R7", 64'(status), 64'hDF);
        tag = "R9";
        step(0, 8'h00, 1, 1, 0, 0);            // read and write when full
        step(0, 8'h00, 0, 1, 0, 0);
        for (int i = 0; i < 34; i++) step(0, 8'h00, 0, 1, 0, 0);
        chk("R9", 64'(status), 64'h20);

        tag = "R4";
        step(1, 8'h8A, 0, 0, 0, 0);            // circular, level 10
        for (int i = 0; i < 45; i++) step(0, 8'h00, 1, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 8'h00, 0, 1, 0, 0);

        tag = "R5";
        step(1, 8'hC0, 0, 0, 0, 0);            // freeze on evt_a
        for (int i = 0; i < 36; i++) step(0, 8'h00, 1, 0, 0, 1);
        step(0, 8'h00, 1, 0, 1, 0);            // trigger cycle: still circular
        for (int i = 0; i < 5; i++) step(0, 8'h00, 1, 0, 0, 0);
        step(0, 8'h00, 0, 1, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 8'h00, 1, 0, 0, 0);
        step(1, 8'hE3, 0, 0, 0, 0);            // freeze on evt_b
        for (int i = 0; i < 34; i++) step(0, 8'h00, 1, 0, 1, 0);
        step(0, 8'h00, 0, 0, 0, 1);
        for (int i = 0; i < 4; i++) step(0, 8'h00, 1, 0, 0, 0);

        tag = "R9";
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom_range(0, 99));
            if (r < 2) step(1, 8'($urandom), 0, 0, 0, 0);
            else step(0, 8'h00, r < 70, ($urandom_range(0, 2) == 0), r == 50, r == 51);
        end
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule